// File: doc/BRIEF.md
# Three-wire serial configuration loader

This block receives configuration for a dual frequency synthesizer over a write-only three-wire port made of a serial clock, a serial data line and a load enable. Each rising serial clock moves one data bit, most significant bit first, into a 22-bit frame register. A rising load enable takes the two least significant bits of that frame as an address. It copies the other twenty bits into one of four configuration words: the reference-divider word, the IF feedback-divider word, the RF feedback-divider word or the RF fraction word.

All three serial lines are asynchronous to the system clock. They pass through synchronizers, and the block detects edges on the system clock, which must run well above the serial clock (the serial clock runs at up to 10 MHz). Every word drives its decoded fields straight to the counters, the charge pumps and the output multiplexer. Each word also raises a one-cycle update strobe when it is written, so that a counter can reload its preset. A word keeps its value until a later frame addresses it.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and after its release, every decoded field and every strobe is zero until the first load.
- R2: Every rising `ser_clk` shifts `ser_data` into the frame register, MSB first. Every rising `ser_le` loads frame bits [21:2] into the word that frame bits [1:0] select: 00 selects the reference word, 01 the IF divider word, 10 the RF divider word and 11 the fraction word.
- R3: Reference word fields, by frame bit: [21] `if_cnt_rst`, [20] `if_pwdn`, [19] `pwdn_sync`, [18:17] `rf_r_div`, [16:2] `if_r_div`.
- R4: IF divider word fields: [21] `fastlock_sel`, [20] `out1_lvl`, [19] `out0_lvl`, [18] `if_cp_hi`, [17] `if_pfd_pos`, [16:5] `if_b_cnt`, [4:2] `if_a_cnt`.
- R5: RF divider word fields: [21:18] `lock_mux_sel`, [17:14] `rf_cp_lvl`, [13] `rf_pfd_pos`, [12:6] `rf_b_cnt`, [5:2] `rf_a_cnt`.
- R6: Fraction word fields: [21] `rf_cnt_rst`, [20] `rf_pwdn`, [19] `frac_en`, [18:2] `frac_val`. `frac_val` is a 17-bit two's complement value, so code 1_1011_1011_1100_0000 reads as -17472.
- R7: A load changes only the addressed word. The other three words keep their values.
- R8: Every load raises exactly one bit of `word_upd` for exactly one cycle. Bit 0 marks the reference word, bit 1 the IF divider word, bit 2 the RF divider word and bit 3 the fraction word.
- R9: When fewer than 22 serial clocks come before a load, the word takes the most recent 22 bits shifted in, and bits from earlier frames fill the upper positions.
- R10: When more than 22 serial clocks come before a load, only the last 22 bits count.
- R11: Holding `ser_le` high causes one load only. Serial clocks that arrive while it is high still shift, and a later rising `ser_le` loads those bits.
- R12: When a rising `ser_clk` and a rising `ser_le` reach the block in the same system cycle, the load takes the frame as it was before that bit. The bit still enters the frame register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load enable, acts on its rising edge |
| if_cnt_rst | output | 1 | IF counter reset request |
| if_pwdn | output | 1 | IF power-down request |
| pwdn_sync | output | 1 | Power-down waits for the end of a pump pulse |
| rf_r_div | output | 2 | RF reference divide ratio |
| if_r_div | output | 15 | IF reference divide ratio |
| fastlock_sel | output | 1 | Output pins act as fast-lock switches |
| out1_lvl | output | 1 | Programmed level of general output 1 |
| out0_lvl | output | 1 | Programmed level of general output 0 |
| if_cp_hi | output | 1 | IF pump at high gain |
| if_pfd_pos | output | 1 | IF detector positive slope |
| if_b_cnt | output | 12 | IF main count |
| if_a_cnt | output | 3 | IF swallow count |
| lock_mux_sel | output | 4 | Monitor output selection |
| rf_cp_lvl | output | 4 | RF pump level code |
| rf_pfd_pos | output | 1 | RF detector positive slope |
| rf_b_cnt | output | 7 | RF main count |
| rf_a_cnt | output | 4 | RF swallow count |
| rf_cnt_rst | output | 1 | RF counter reset request |
| rf_pwdn | output | 1 | RF power-down request |
| frac_en | output | 1 | Fractional mode enable |
| frac_val | output | 17 | Signed fraction value |
| word_upd | output | 4 | One-cycle update strobe, one bit per word |

## Verification
A serial clock edge and a load edge can land in the same system cycle, so one clock edge both shifts the frame and copies it. The bench raises `ser_clk` and `ser_le` at the same instant, which makes both edge detectors fire on the same cycle. It then expects the addressed word to hold the frame from before the new bit. After that it sends a second load with no clocks in between. That load must show the frame moved up one place with the new bit at the bottom, which shows the colliding bit was kept and not lost.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int ADDR_W  = 2;
  localparam int PAY_W   = 20;
  localparam int FRAME_W = PAY_W + ADDR_W;
  localparam int NWORDS  = 1 << ADDR_W;

  typedef logic [PAY_W-1:0] pay_t;

  typedef struct packed {
    logic        if_cnt_rst;
    logic        if_pwdn;
    logic        pwdn_sync;
    logic [1:0]  rf_r;
    logic [14:0] if_r;
  } ref_word_t;

  typedef struct packed {
    logic        fastlock;
    logic        out1;
    logic        out0;
    logic        cp_hi;
    logic        pfd_pos;
    logic [11:0] b_cnt;
    logic [2:0]  a_cnt;
  } ifdiv_word_t;

  typedef struct packed {
    logic [3:0]  mux_sel;
    logic [3:0]  cp_lvl;
    logic        pfd_pos;
    logic [6:0]  b_cnt;
    logic [3:0]  a_cnt;
  } rfdiv_word_t;

  typedef struct packed {
    logic        cnt_rst;
    logic        pwdn;
    logic        frac_en;
    logic [16:0] frac;
  } frac_word_t;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = async_in;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign lvl = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_rise_det.sv
module cfg_rise_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int FRAME_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {frame_q[FRAME_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign frame = frame_q;
endmodule

// File: rtl/cfg_word_bank.sv
module cfg_word_bank #(
  parameter int PAY_W  = 20,
  parameter int ADDR_W = 2,
  localparam int NW    = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [PAY_W+ADDR_W-1:0]    frame,
  output logic [NW-1:0][PAY_W-1:0]   words,
  output logic [NW-1:0]              upd
);
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  payload;

  assign addr    = frame[ADDR_W-1:0];
  assign payload = frame[PAY_W+ADDR_W-1:ADDR_W];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic             sel;
    logic [PAY_W-1:0] word_q;
    logic [PAY_W-1:0] word_d;
    logic             upd_q;
    logic             upd_d;

    assign sel = load_en && (addr == ADDR_W'(w));

    always_comb begin
      word_d = word_q;
      if (sel) word_d = payload;
      upd_d = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        upd_q  <= 1'b0;
      end else begin
        word_q <= word_d;
        upd_q  <= upd_d;
      end
    end

    assign words[w] = word_q;
    assign upd[w]   = upd_q;
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  output logic               if_cnt_rst,
  output logic               if_pwdn,
  output logic               pwdn_sync,
  output logic [1:0]         rf_r_div,
  output logic [14:0]        if_r_div,
  output logic               fastlock_sel,
  output logic               out1_lvl,
  output logic               out0_lvl,
  output logic               if_cp_hi,
  output logic               if_pfd_pos,
  output logic [11:0]        if_b_cnt,
  output logic [2:0]         if_a_cnt,
  output logic [3:0]         lock_mux_sel,
  output logic [3:0]         rf_cp_lvl,
  output logic               rf_pfd_pos,
  output logic [6:0]         rf_b_cnt,
  output logic [3:0]         rf_a_cnt,
  output logic               rf_cnt_rst,
  output logic               rf_pwdn,
  output logic               frac_en,
  output logic signed [16:0] frac_val,
  output logic [3:0]         word_upd
);
  localparam int IN_W  = 3;
  localparam int EDG_W = 2;

  logic                          rst_i_n;
  logic [IN_W-1:0]               in_lvl;
  logic [EDG_W-1:0]              in_rise;
  logic                          sck_rise;
  logic                          le_rise;
  logic [FRAME_W-1:0]            frame;
  logic [NWORDS-1:0][PAY_W-1:0]  words;

  ref_word_t   w_ref;
  ifdiv_word_t w_if;
  rfdiv_word_t w_rf;
  frac_word_t  w_fr;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cfg_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .async_in ({ser_le, ser_data, ser_clk}),
    .lvl      (in_lvl)
  );

  cfg_rise_det #(.WIDTH(EDG_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lvl   ({in_lvl[2], in_lvl[0]}),
    .rise  (in_rise)
  );

  assign sck_rise = in_rise[0];
  assign le_rise  = in_rise[1];

  cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .shift_en (sck_rise),
    .bit_in   (in_lvl[1]),
    .frame    (frame)
  );

  cfg_word_bank #(.PAY_W(PAY_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load_en (le_rise),
    .frame   (frame),
    .words   (words),
    .upd     (word_upd)
  );

  assign w_ref = ref_word_t'(words[0]);
  assign w_if  = ifdiv_word_t'(words[1]);
  assign w_rf  = rfdiv_word_t'(words[2]);
  assign w_fr  = frac_word_t'(words[3]);

  assign if_cnt_rst   = w_ref.if_cnt_rst;
  assign if_pwdn      = w_ref.if_pwdn;
  assign pwdn_sync    = w_ref.pwdn_sync;
  assign rf_r_div     = w_ref.rf_r;
  assign if_r_div     = w_ref.if_r;

  assign fastlock_sel = w_if.fastlock;
  assign out1_lvl     = w_if.out1;
  assign out0_lvl     = w_if.out0;
  assign if_cp_hi     = w_if.cp_hi;
  assign if_pfd_pos   = w_if.pfd_pos;
  assign if_b_cnt     = w_if.b_cnt;
  assign if_a_cnt     = w_if.a_cnt;

  assign lock_mux_sel = w_rf.mux_sel;
  assign rf_cp_lvl    = w_rf.cp_lvl;
  assign rf_pfd_pos   = w_rf.pfd_pos;
  assign rf_b_cnt     = w_rf.b_cnt;
  assign rf_a_cnt     = w_rf.a_cnt;

  assign rf_cnt_rst   = w_fr.cnt_rst;
  assign rf_pwdn      = w_fr.pwdn;
  assign frac_en      = w_fr.frac_en;
  assign frac_val     = $signed(w_fr.frac);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              le_rise,
  input logic [3:0]        word_upd,
  input logic [3:0][19:0]  words
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (words == '0 && word_upd == 4'b0));

  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_upd));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|word_upd) |=> !(|word_upd));

  p_load_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> ($countones(word_upd) == 1));

  p_strobe_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|word_upd) |-> $past(le_rise));

  for (genvar k = 0; k < 4; k++) begin : g_hold
    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !word_upd[k] |-> $stable(words[k]));
  end
endmodule

bind cfg_serial_loader cfg_loader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .le_rise  (le_rise),
  .word_upd (word_upd),
  .words    (words)
);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic if_cnt_rst, if_pwdn, pwdn_sync;
  logic [1:0] rf_r_div;
  logic [14:0] if_r_div;
  logic fastlock_sel, out1_lvl, out0_lvl, if_cp_hi, if_pfd_pos;
  logic [11:0] if_b_cnt;
  logic [2:0] if_a_cnt;
  logic [3:0] lock_mux_sel, rf_cp_lvl;
  logic rf_pfd_pos;
  logic [6:0] rf_b_cnt;
  logic [3:0] rf_a_cnt;
  logic rf_cnt_rst, rf_pwdn, frac_en;
  logic signed [16:0] frac_val;
  logic [3:0] word_upd;

  always #4 clk = ~clk;

  cfg_serial_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .if_cnt_rst(if_cnt_rst), .if_pwdn(if_pwdn), .pwdn_sync(pwdn_sync),
    .rf_r_div(rf_r_div), .if_r_div(if_r_div), .fastlock_sel(fastlock_sel),
    .out1_lvl(out1_lvl), .out0_lvl(out0_lvl), .if_cp_hi(if_cp_hi), .if_pfd_pos(if_pfd_pos),
    .if_b_cnt(if_b_cnt), .if_a_cnt(if_a_cnt), .lock_mux_sel(lock_mux_sel),
    .rf_cp_lvl(rf_cp_lvl), .rf_pfd_pos(rf_pfd_pos), .rf_b_cnt(rf_b_cnt),
    .rf_a_cnt(rf_a_cnt), .rf_cnt_rst(rf_cnt_rst), .rf_pwdn(rf_pwdn),
    .frac_en(frac_en), .frac_val(frac_val), .word_upd(word_upd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_strobe = 0;
  int n_loads = 0;
  logic [21:0] bshift = '0;
  logic [19:0] model [4] = '{default: '0};
  logic [21:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [19:0] seen(input int k);
    case (k)
      0: seen = {if_cnt_rst, if_pwdn, pwdn_sync, rf_r_div, if_r_div};
      1: seen = {fastlock_sel, out1_lvl, out0_lvl, if_cp_hi, if_pfd_pos, if_b_cnt, if_a_cnt};
      2: seen = {lock_mux_sel, rf_cp_lvl, rf_pfd_pos, rf_b_cnt, rf_a_cnt};
      default: seen = {rf_cnt_rst, rf_pwdn, frac_en, frac_val};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops the expected load at each strobe and compares all four words
  always @(negedge clk) begin
    if (rst_n && word_upd != 4'b0) begin
      n_strobe++;
      if (exp_q.size() == 0) begin
        check("R11 unexpected strobe", {28'b0, word_upd}, 32'b0);
      end else begin
        logic [21:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " R8 strobe"}, {28'b0, word_upd}, 32'b1 << e[1:0]);
        model[e[1:0]] = e[21:2];
        for (int k = 0; k < 4; k++)
          check($sformatf("%s R7 word%0d", t, k), {12'b0, seen(k)}, {12'b0, model[k]});
      end
    end
  end

  task automatic ser_bit(input logic b);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    bshift = {bshift[20:0], b};
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ser_load(input string tag);
    @(negedge clk) ser_le = 1'b1;
    exp_q.push_back(bshift); tag_q.push_back(tag); n_loads++;
    repeat (6) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] adr, input logic [19:0] pay, input string tag);
    logic [21:0] f;
    f = {pay, adr};
    for (int i = 21; i >= 0; i--) ser_bit(f[i]);
    ser_load(tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 4; k++) check($sformatf("R1 word%0d", k), {12'b0, seen(k)}, 32'b0);
    check("R1 strobe", {28'b0, word_upd}, 32'b0);

    // R2/R3: reference word, one field per distinct value
    send_frame(2'b00, {1'b1, 1'b0, 1'b1, 2'b10, 15'h4ABC}, "R3");
    check("R3 if_r_div", {17'b0, if_r_div}, 32'h4ABC);
    check("R3 rf_r_div", {30'b0, rf_r_div}, 32'd2);
    // R4: IF divider word
    send_frame(2'b01, {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hA53, 3'd5}, "R4");
    check("R4 if_b_cnt", {20'b0, if_b_cnt}, 32'hA53);
    check("R4 out1_lvl", {31'b0, out1_lvl}, 32'd1);
    // R5: RF divider word
    send_frame(2'b10, {4'b0001, 4'b1011, 1'b1, 7'd12, 4'd9}, "R5");
    check("R5 rf_cp_lvl", {28'b0, rf_cp_lvl}, 32'd11);
    check("R5 rf_a_cnt", {28'b0, rf_a_cnt}, 32'd9);
    // R6: fraction word, negative two's complement value
    send_frame(2'b11, {1'b0, 1'b1, 1'b1, 17'h1BBC0}, "R6");
    check("R6 frac_val", 32'($signed(frac_val)), 32'(-17472));
    check("R6 frac_en", {31'b0, frac_en}, 32'd1);
    // R7: rewrite one word, others must hold (monitor compares all four)
    send_frame(2'b01, 20'hFFFFF, "R7 R2");
    send_frame(2'b00, 20'h00003, "R7 R2");

    // R9: short frame of 8 clocks keeps older bits
    for (int i = 0; i < 8; i++) ser_bit(i[0]);
    ser_load("R9");
    // R10: long frame of 30 clocks keeps the last 22
    for (int i = 0; i < 30; i++) ser_bit(i[1] ^ i[2]);
    ser_load("R10");

    // R11: LE held high while clocks continue
    @(negedge clk) ser_le = 1'b1;
    exp_q.push_back(bshift); tag_q.push_back("R11"); n_loads++;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 22; i++) ser_bit(i[0] | i[3]);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
    check("R11 strobe count", n_strobe, n_loads);
    ser_load("R11");

    // R12: serial clock and load enable rise together
    @(negedge clk) ser_data = ~bshift[0];
    repeat (3) @(negedge clk);
    ser_clk = 1'b1; ser_le = 1'b1;
    exp_q.push_back(bshift); tag_q.push_back("R12"); n_loads++;
    bshift = {bshift[20:0], ser_data};
    repeat (6) @(negedge clk);
    ser_clk = 1'b0; ser_le = 1'b0;
    repeat (6) @(negedge clk);
    ser_load("R12");

    repeat (10) @(negedge clk);
    check("R8 total strobes", n_strobe, n_loads);
    check("R2 queue drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule